// File: doc/BRIEF.md
# Quad-Word Load/Store Sequencer

This block executes one instruction from a paired 128-bit load/store group on a 64-bit core. It takes one instruction word, splits it into two 64-bit memory accesses, and runs them in sequence. The first access goes to the effective address. The second goes to the effective address plus 8. Loads write both doublewords into two registers of the integer or floating-point file. Stores send the two supplied register values to memory. Instruction words whose sub-selector is not a quad-word form raise a reserved-instruction exception. Floating-point forms issued while coprocessor 1 is disabled raise a coprocessor-unusable exception. In both exception cases no memory access takes place.

The issue stage presents the instruction together with the base register value. For stores it also presents the two source operands: the value of register rt and the value of the register named by bits 4:0. Those operands come from the integer or floating-point file, whichever the form selects. The sequencer captures all of these in the cycle it accepts the instruction. It then keeps `busy` high until its write-back cycle has passed. The memory side is a plain request/acknowledge port. Data is handled as 64-bit little-endian words.

Top module: `qword_ls_unit`

## Requirements
- R1: An instruction is taken only when `instr_valid` is high and the unit is idle. Its major opcode must be bits 31:26 = 6'b110010 (load group) or 6'b111010 (store group). Any other major opcode is ignored: no access, no write and no exception. Within the group, {bit15, bit5} = 2'b01 selects the integer register file and 2'b11 selects the floating-point register file.
- R2: In the group, {bit15, bit5} = 2'b00 or 2'b10 pulses `exc_reserved` for one cycle, in the cycle after acceptance. No memory access and no register write follow.
- R3: A floating-point form accepted while `cop1_en` is low pulses `exc_cop_unusable` for one cycle. No memory access and no register write follow.
- R4: The offset is instruction bits 14:6, sign-extended as a 9-bit value and multiplied by 16. The first access uses base + offset. The second access uses base + offset + 8. The two accesses always occur in that order.
- R5: For a load, the lower-address doubleword goes to register rt (bits 20:16). The higher-address doubleword goes to the register named by bits 4:0. Both writes happen in the same single cycle, on the write port of the selected file only.
- R6: For a store, `st_data_a` is written to the lower address and `st_data_b` to the higher address. Each store access has `mem_we` = 1 and `mem_strb` = 8'hFF. Loads have `mem_we` = 0.
- R7: `busy` is high from the cycle after acceptance until the write-back cycle ends. An `instr_valid` that arrives while `busy` is high is dropped.
- R8: An access keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high.
- R9: Load register writes happen only after both memory reads have been acknowledged. A destination that equals the base register therefore cannot disturb the second address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word presented |
| instr_word | input | 32 | Instruction word |
| base_val | input | 64 | Value of the base register |
| cop1_en | input | 1 | Coprocessor 1 usable |
| st_data_a | input | 64 | Store operand for register rt |
| st_data_b | input | 64 | Store operand for the register in bits 4:0 |
| busy | output | 1 | Sequence in progress |
| exc_reserved | output | 1 | Reserved-instruction exception pulse |
| exc_cop_unusable | output | 1 | Coprocessor-unusable exception pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 64 | Access byte address |
| mem_wdata | output | 64 | Write data |
| mem_strb | output | 8 | Byte strobes for writes |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| gpr_we | output | 1 | Integer register write enable |
| gpr_idx_a | output | 5 | Integer register index, lower doubleword |
| gpr_data_a | output | 64 | Lower doubleword |
| gpr_idx_b | output | 5 | Integer register index, upper doubleword |
| gpr_data_b | output | 64 | Upper doubleword |
| fpr_we | output | 1 | Floating-point register write enable |
| fpr_idx_a | output | 5 | Floating-point register index, lower doubleword |
| fpr_data_a | output | 64 | Lower doubleword |
| fpr_idx_b | output | 5 | Floating-point register index, upper doubleword |
| fpr_data_b | output | 64 | Upper doubleword |

## Verification
Loads and stores are each run through both register files. This tells apart the file-select decode and the direction of data flow. Offset fields of positive, -1 and most-negative value confirm the sign extension and the scaling by 16, and the bench compares the two recorded access addresses and their order. All four sub-selector codes are tried in both major groups, together with a disabled coprocessor and a foreign opcode, so each exception path is separated from a silent drop. Acknowledge latencies of zero and several cycles, plus an instruction offered mid-sequence, show that write-back waits for both reads and that the unit ignores work while busy.

// File: rtl/qls_pkg.sv
// Shared definitions for the quad-word load/store sequencer.
// Assumes the fixed 32-bit instruction format of the paired load/store group.
package qls_pkg;
    localparam logic [5:0] OPC_LOAD_GRP  = 6'b110010;
    localparam logic [5:0] OPC_STORE_GRP = 6'b111010;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ACCESS_LO,
        SEQ_ACCESS_HI,
        SEQ_DONE
    } seq_state_t;

    typedef struct packed {
        logic       in_group;
        logic       is_store;
        logic       is_fp;
        logic       illegal;
        logic [4:0] idx_a;
        logic [4:0] idx_b;
        logic [8:0] off_field;
    } qls_dec_t;
endpackage

// File: rtl/qls_decode.sv
// Instruction decoder for the paired load/store group.
// Pure combinational logic. It reports group membership, direction, register
// file and legality. The caller is responsible for qualifying with instr_valid.
module qls_decode
    import qls_pkg::*;
(
    input  logic [31:0] instr,
    output qls_dec_t    dec
);
    logic [5:0] major;
    logic [1:0] sel;

    // Split the opcode fields and classify the word.
    always_comb begin
        major         = instr[31:26];
        sel           = {instr[15], instr[5]};
        dec.in_group  = (major == OPC_LOAD_GRP) || (major == OPC_STORE_GRP);
        dec.is_store  = (major == OPC_STORE_GRP);
        dec.is_fp     = (sel == 2'b11);
        dec.illegal   = dec.in_group && (sel[0] == 1'b0);
        dec.idx_a     = instr[20:16];
        dec.idx_b     = instr[4:0];
        dec.off_field = instr[14:6];
    end
endmodule

// File: rtl/qls_agen.sv
// Address generator. It sign-extends the packed offset field, scales it, adds
// the base, and gives the two doubleword addresses of the pair.
// Assumes no alignment checking; addresses wrap at AW bits.
module qls_agen #(
    parameter int AW        = 64,
    parameter int OFF_W     = 9,
    parameter int OFF_SHIFT = 4,
    parameter int STEP      = 8
) (
    input  logic [AW-1:0]    base,
    input  logic [OFF_W-1:0] off_field,
    output logic [AW-1:0]    addr_lo,
    output logic [AW-1:0]    addr_hi
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] off_ext;

    // Sign-extend, scale and add the offset to the base.
    always_comb begin
        off_ext = {{(AW-OFF_W){off_field[OFF_W-1]}}, off_field} << OFF_SHIFT;
        addr_lo = base + off_ext;
        addr_hi = addr_lo + STEP_V;
    end
endmodule

// File: rtl/qls_seq.sv
// Access sequencer. It accepts one decoded instruction while idle, raises
// exceptions for illegal or disabled forms, then issues the low and high
// accesses and performs the load write-back in SEQ_DONE.
// Assumes the memory holds each request until mem_ack; mem_rdata is valid with mem_ack.
module qls_seq
    import qls_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  qls_dec_t          dec,
    input  logic              cop1_en,
    input  logic [XLEN-1:0]   addr_lo_in,
    input  logic [XLEN-1:0]   addr_hi_in,
    input  logic [XLEN-1:0]   st_data_a,
    input  logic [XLEN-1:0]   st_data_b,
    output logic              busy,
    output logic              exc_reserved,
    output logic              exc_cop_unusable,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [XLEN/8-1:0] mem_strb,
    input  logic              mem_ack,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              wb_int,
    output logic              wb_fp,
    output logic [IDX_W-1:0]  wb_idx_a,
    output logic [IDX_W-1:0]  wb_idx_b,
    output logic [XLEN-1:0]   wb_data_a,
    output logic [XLEN-1:0]   wb_data_b
);
    localparam int SW = XLEN / 8;

    seq_state_t       state;
    logic             r_store;
    logic             r_fp;
    logic [IDX_W-1:0] r_idx_a;
    logic [IDX_W-1:0] r_idx_b;
    logic [XLEN-1:0]  r_addr_lo;
    logic [XLEN-1:0]  r_addr_hi;
    logic [XLEN-1:0]  buf_a;
    logic [XLEN-1:0]  buf_b;
    logic             accept;
    logic             cop_block;
    logic             start;

    // Decide whether the presented word is taken and whether it may run.
    always_comb begin
        accept    = instr_valid && dec.in_group && (state == SEQ_IDLE);
        cop_block = dec.is_fp && !cop1_en;
        start     = accept && !dec.illegal && !cop_block;
    end

    // State, captured operands and exception pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state            <= SEQ_IDLE;
            r_store          <= 1'b0;
            r_fp             <= 1'b0;
            r_idx_a          <= '0;
            r_idx_b          <= '0;
            r_addr_lo        <= '0;
            r_addr_hi        <= '0;
            buf_a            <= '0;
            buf_b            <= '0;
            exc_reserved     <= 1'b0;
            exc_cop_unusable <= 1'b0;
        end else begin
            exc_reserved     <= accept && dec.illegal;
            exc_cop_unusable <= accept && !dec.illegal && cop_block;
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state     <= SEQ_ACCESS_LO;
                        r_store   <= dec.is_store;
                        r_fp      <= dec.is_fp;
                        r_idx_a   <= dec.idx_a;
                        r_idx_b   <= dec.idx_b;
                        r_addr_lo <= addr_lo_in;
                        r_addr_hi <= addr_hi_in;
                        buf_a     <= st_data_a;
                        buf_b     <= st_data_b;
                    end
                end
                SEQ_ACCESS_LO: begin
                    if (mem_ack) begin
                        state <= SEQ_ACCESS_HI;
                        if (!r_store) buf_a <= mem_rdata;
                    end
                end
                SEQ_ACCESS_HI: begin
                    if (mem_ack) begin
                        state <= SEQ_DONE;
                        if (!r_store) buf_b <= mem_rdata;
                    end
                end
                SEQ_DONE: state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    // Drive the memory port from the current access state.
    always_comb begin
        mem_req   = (state == SEQ_ACCESS_LO) || (state == SEQ_ACCESS_HI);
        mem_we    = mem_req && r_store;
        mem_addr  = (state == SEQ_ACCESS_HI) ? r_addr_hi : r_addr_lo;
        mem_wdata = (state == SEQ_ACCESS_HI) ? buf_b : buf_a;
        mem_strb  = mem_we ? {SW{1'b1}} : {SW{1'b0}};
    end

    // Drive the write-back lanes and busy.
    always_comb begin
        busy      = (state != SEQ_IDLE);
        wb_int    = (state == SEQ_DONE) && !r_store && !r_fp;
        wb_fp     = (state == SEQ_DONE) && !r_store && r_fp;
        wb_idx_a  = r_idx_a;
        wb_idx_b  = r_idx_b;
        wb_data_a = buf_a;
        wb_data_b = buf_b;
    end

    // R8: a pending access holds still until acknowledged.
    assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9: write-back only in the cycle following the last acknowledge.
    assert_wb_after_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_int || wb_fp) |-> $past(mem_ack));

    // R5: at most one register file written at a time.
    assert_single_file_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_int, wb_fp}));

    // R2: the two exceptions are exclusive.
    assert_exc_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_reserved && exc_cop_unusable));

    // R3: an exception pulse is never accompanied by or followed by an access.
    assert_exc_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_reserved || exc_cop_unusable) |-> (!mem_req && !busy));

    // R7: busy rises together with the first access.
    assert_busy_starts_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && $past(instr_valid)));
endmodule

// File: rtl/qword_ls_unit.sv
// Top of the quad-word load/store sequencer. It ties the decoder and the
// address generator to the access sequencer and fans the write-back lanes
// out to the integer and floating-point write ports.
// Assumes the issue stage holds base and store operands stable while instr_valid is high.
module qword_ls_unit
    import qls_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    input  logic [XLEN-1:0]   base_val,
    input  logic              cop1_en,
    input  logic [XLEN-1:0]   st_data_a,
    input  logic [XLEN-1:0]   st_data_b,
    output logic              busy,
    output logic              exc_reserved,
    output logic              exc_cop_unusable,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [XLEN/8-1:0] mem_strb,
    input  logic              mem_ack,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              gpr_we,
    output logic [IDX_W-1:0]  gpr_idx_a,
    output logic [XLEN-1:0]   gpr_data_a,
    output logic [IDX_W-1:0]  gpr_idx_b,
    output logic [XLEN-1:0]   gpr_data_b,
    output logic              fpr_we,
    output logic [IDX_W-1:0]  fpr_idx_a,
    output logic [XLEN-1:0]   fpr_data_a,
    output logic [IDX_W-1:0]  fpr_idx_b,
    output logic [XLEN-1:0]   fpr_data_b
);
    localparam int OFF_W     = 9;
    localparam int OFF_SHIFT = 4;
    localparam int STEP      = XLEN / 8;

    qls_dec_t         dec;
    logic [XLEN-1:0]  addr_lo;
    logic [XLEN-1:0]  addr_hi;
    logic             wb_int;
    logic             wb_fp;
    logic [IDX_W-1:0] wb_idx_a;
    logic [IDX_W-1:0] wb_idx_b;
    logic [XLEN-1:0]  wb_data_a;
    logic [XLEN-1:0]  wb_data_b;

    qls_decode u_decode (
        .instr (instr_word),
        .dec   (dec)
    );

    qls_agen #(
        .AW        (XLEN),
        .OFF_W     (OFF_W),
        .OFF_SHIFT (OFF_SHIFT),
        .STEP      (STEP)
    ) u_agen (
        .base      (base_val),
        .off_field (dec.off_field),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi)
    );

    qls_seq #(
        .XLEN  (XLEN),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .instr_valid      (instr_valid),
        .dec              (dec),
        .cop1_en          (cop1_en),
        .addr_lo_in       (addr_lo),
        .addr_hi_in       (addr_hi),
        .st_data_a        (st_data_a),
        .st_data_b        (st_data_b),
        .busy             (busy),
        .exc_reserved     (exc_reserved),
        .exc_cop_unusable (exc_cop_unusable),
        .mem_req          (mem_req),
        .mem_we           (mem_we),
        .mem_addr         (mem_addr),
        .mem_wdata        (mem_wdata),
        .mem_strb         (mem_strb),
        .mem_ack          (mem_ack),
        .mem_rdata        (mem_rdata),
        .wb_int           (wb_int),
        .wb_fp            (wb_fp),
        .wb_idx_a         (wb_idx_a),
        .wb_idx_b         (wb_idx_b),
        .wb_data_a        (wb_data_a),
        .wb_data_b        (wb_data_b)
    );

    // Fan the write-back lanes out to both register-file ports.
    always_comb begin
        gpr_we     = wb_int;
        gpr_idx_a  = wb_idx_a;
        gpr_idx_b  = wb_idx_b;
        gpr_data_a = wb_data_a;
        gpr_data_b = wb_data_b;
        fpr_we     = wb_fp;
        fpr_idx_a  = wb_idx_a;
        fpr_idx_b  = wb_idx_b;
        fpr_data_a = wb_data_a;
        fpr_data_b = wb_data_b;
    end
endmodule

// File: tb/tb_qword_ls_unit.sv
`timescale 1ns/1ps
module tb_qword_ls_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [63:0] base_val = '0;
    logic        cop1_en = 1'b1;
    logic [63:0] st_data_a = '0;
    logic [63:0] st_data_b = '0;
    logic        busy, exc_reserved, exc_cop_unusable;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic [7:0]  mem_strb;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        gpr_we, fpr_we;
    logic [4:0]  gpr_idx_a, gpr_idx_b, fpr_idx_a, fpr_idx_b;
    logic [63:0] gpr_data_a, gpr_data_b, fpr_data_a, fpr_data_b;

    qword_ls_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .base_val(base_val), .cop1_en(cop1_en), .st_data_a(st_data_a), .st_data_b(st_data_b),
        .busy(busy), .exc_reserved(exc_reserved), .exc_cop_unusable(exc_cop_unusable),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_strb(mem_strb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .gpr_we(gpr_we), .gpr_idx_a(gpr_idx_a), .gpr_data_a(gpr_data_a),
        .gpr_idx_b(gpr_idx_b), .gpr_data_b(gpr_data_b),
        .fpr_we(fpr_we), .fpr_idx_a(fpr_idx_a), .fpr_data_a(fpr_data_a),
        .fpr_idx_b(fpr_idx_b), .fpr_data_b(fpr_data_b)
    );

    always #2.5 clk = ~clk;

    localparam logic [5:0] OP_LD = 6'b110010;
    localparam logic [5:0] OP_ST = 6'b111010;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // memory model and logs
    logic [63:0] mem [logic [63:0]];
    int          ack_delay = 0;
    int          wait_cnt = 0;
    int          acc_cnt = 0;
    logic [63:0] acc_addr [4];
    logic        acc_we [4];
    logic [7:0]  acc_strb [4];
    int          wb_cnt = 0;
    logic        wb_is_fp = 1'b0;
    logic [4:0]  wb_ia, wb_ib;
    logic [63:0] wb_da, wb_db;
    bit          early_wb = 1'b0;
    int          ri_cnt = 0;
    int          cpu_cnt = 0;

    function automatic logic [63:0] pat(input logic [63:0] a);
        return {a[31:0] ^ 32'hC3A5_5A3C, a[31:0] + 32'h0101_0101};
    endfunction

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return pat(a);
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder and monitors, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (gpr_we || fpr_we) begin
                wb_cnt++;
                wb_is_fp = fpr_we;
                if (acc_cnt < 2) early_wb = 1'b1;
                wb_ia = fpr_we ? fpr_idx_a : gpr_idx_a;
                wb_ib = fpr_we ? fpr_idx_b : gpr_idx_b;
                wb_da = fpr_we ? fpr_data_a : gpr_data_a;
                wb_db = fpr_we ? fpr_data_b : gpr_data_b;
            end
            if (exc_reserved) ri_cnt++;
            if (exc_cop_unusable) cpu_cnt++;
            if (mem_req && !mem_ack) begin
                if (wait_cnt >= ack_delay) begin
                    mem_ack = 1'b1;
                    mem_rdata = rd(mem_addr);
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    if (acc_cnt < 4) begin
                        acc_addr[acc_cnt] = mem_addr;
                        acc_we[acc_cnt] = mem_we;
                        acc_strb[acc_cnt] = mem_strb;
                    end
                    acc_cnt++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic [5:0] op, input logic b15, input logic b5,
                                       input logic [4:0] rt, input logic [4:0] rt2, input logic [8:0] off);
        return {op, 5'd3, rt, b15, off, b5, rt2};
    endfunction

    task automatic clear_logs();
        acc_cnt = 0; wb_cnt = 0; early_wb = 1'b0; ri_cnt = 0; cpu_cnt = 0; wait_cnt = 0;
    endtask

    // present one instruction for one cycle, then wait for completion
    task automatic issue(input logic [31:0] iw, input logic [63:0] base, input logic cop1,
                         input logic [63:0] sa, input logic [63:0] sb);
        clear_logs();
        @(negedge clk);
        instr_word = iw; base_val = base; cop1_en = cop1; st_data_a = sa; st_data_b = sb;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        for (int i = 0; i < 60 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R7", "busy after reset", {63'd0, busy}, 64'd0);
        chk("R8", "mem_req after reset", {63'd0, mem_req}, 64'd0);
        chk("R2", "exc after reset", {62'd0, exc_reserved, exc_cop_unusable}, 64'd0);
        chk("R5", "writes after reset", {62'd0, gpr_we, fpr_we}, 64'd0);
    endtask

    task automatic t_load(input string tag, input logic fp, input logic [63:0] base,
                          input logic [8:0] off, input logic [4:0] ra, input logic [4:0] rb, input int dly);
        logic [63:0] lo;
        lo = base + ({{55{off[8]}}, off} << 4);
        ack_delay = dly;
        issue(mk(OP_LD, fp, 1'b1, ra, rb, off), base, 1'b1, '0, '0);
        chk(tag, "access count", 64'(acc_cnt), 64'd2);
        chk("R4", "first address", acc_addr[0], lo);
        chk("R4", "second address", acc_addr[1], lo + 64'd8);
        chk("R6", "load we", {62'd0, acc_we[0], acc_we[1]}, 64'd0);
        chk("R5", "write count", 64'(wb_cnt), 64'd1);
        chk("R1", "file select", {63'd0, wb_is_fp}, {63'd0, fp});
        chk("R5", "index a", {59'd0, wb_ia}, {59'd0, ra});
        chk("R5", "index b", {59'd0, wb_ib}, {59'd0, rb});
        chk("R5", "data low", wb_da, rd(lo));
        chk("R5", "data high", wb_db, rd(lo + 64'd8));
        chk("R9", "write before reads", {63'd0, early_wb}, 64'd0);
    endtask

    task automatic t_store(input logic fp, input logic [63:0] base, input logic [8:0] off,
                           input logic [63:0] sa, input logic [63:0] sb);
        logic [63:0] lo;
        lo = base + ({{55{off[8]}}, off} << 4);
        ack_delay = 1;
        issue(mk(OP_ST, fp, 1'b1, 5'd9, 5'd10, off), base, 1'b1, sa, sb);
        chk("R6", "access count", 64'(acc_cnt), 64'd2);
        chk("R4", "store first address", acc_addr[0], lo);
        chk("R4", "store second address", acc_addr[1], lo + 64'd8);
        chk("R6", "store we", {62'd0, acc_we[0], acc_we[1]}, 64'd3);
        chk("R6", "strobe", {48'd0, acc_strb[0], acc_strb[1]}, 64'hFFFF);
        chk("R6", "mem low", rd(lo), sa);
        chk("R6", "mem high", rd(lo + 64'd8), sb);
        chk("R6", "no reg write", 64'(wb_cnt), 64'd0);
    endtask

    task automatic t_reserved(input logic [5:0] op, input logic b15);
        issue(mk(op, b15, 1'b0, 5'd1, 5'd2, 9'd4), 64'h4000, 1'b1, 64'd1, 64'd2);
        chk("R2", "reserved pulses", 64'(ri_cnt), 64'd1);
        chk("R2", "reserved access", 64'(acc_cnt), 64'd0);
        chk("R2", "reserved writes", 64'(wb_cnt), 64'd0);
    endtask

    task automatic t_cop_off(input logic [5:0] op);
        issue(mk(op, 1'b1, 1'b1, 5'd4, 5'd5, 9'd1), 64'h5000, 1'b0, 64'd7, 64'd8);
        chk("R3", "cop unusable pulses", 64'(cpu_cnt), 64'd1);
        chk("R3", "cop reserved pulses", 64'(ri_cnt), 64'd0);
        chk("R3", "cop access", 64'(acc_cnt), 64'd0);
        chk("R3", "cop writes", 64'(wb_cnt), 64'd0);
    endtask

    task automatic t_foreign();
        issue(mk(6'b100011, 1'b0, 1'b1, 5'd1, 5'd2, 9'd0), 64'h6000, 1'b1, '0, '0);
        chk("R1", "foreign access", 64'(acc_cnt), 64'd0);
        chk("R1", "foreign exceptions", 64'(ri_cnt + cpu_cnt), 64'd0);
        chk("R1", "foreign writes", 64'(wb_cnt), 64'd0);
    endtask

    task automatic t_busy_drop();
        clear_logs();
        ack_delay = 3;
        @(negedge clk);
        instr_word = mk(OP_LD, 1'b0, 1'b1, 5'd12, 5'd13, 9'd2); base_val = 64'h7000; cop1_en = 1'b1;
        instr_valid = 1'b1;
        @(negedge clk);
        chk("R7", "busy after accept", {63'd0, busy}, 64'd1);
        instr_word = mk(OP_ST, 1'b0, 1'b1, 5'd14, 5'd15, 9'd6); base_val = 64'h9000;
        @(negedge clk);
        instr_valid = 1'b0;
        for (int i = 0; i < 60 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R7", "busy low at end", {63'd0, busy}, 64'd0);
        chk("R7", "dropped access count", 64'(acc_cnt), 64'd2);
        chk("R7", "dropped no write", {62'd0, acc_we[0], acc_we[1]}, 64'd0);
        chk("R7", "first address kept", acc_addr[0], 64'h7020);
        chk("R9", "single write", 64'(wb_cnt), 64'd1);
        chk("R9", "write before reads", {63'd0, early_wb}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load("R1", 1'b0, 64'h1000, 9'd3, 5'd5, 5'd7, 0);
        t_load("R1", 1'b1, 64'h2000, 9'h1FF, 5'd2, 5'd30, 2);
        t_load("R4", 1'b0, 64'h0001_0000, 9'h100, 5'd31, 5'd0, 4);
        t_store(1'b0, 64'h3000, 9'd5, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00);
        t_store(1'b1, 64'h3800, 9'h1FE, 64'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_F0F0_F0F0_F0F0);
        t_reserved(OP_LD, 1'b0);
        t_reserved(OP_LD, 1'b1);
        t_reserved(OP_ST, 1'b0);
        t_reserved(OP_ST, 1'b1);
        t_cop_off(OP_LD);
        t_cop_off(OP_ST);
        t_foreign();
        t_busy_drop();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule